// File: doc/BRIEF.md
# Sector Bit-Flip Corrector

This block finishes a BCH-8 correction for one 512-byte sector once an upstream decoder has found the error positions. The decoder delivers a 4-bit error count, a code-ready flag and up to eight 13-bit error positions. The positions are packed back to back into 104 bits: three 32-bit words followed by one extra byte.

After a `start` pulse the block waits for the ready flag. It then captures the inputs and walks the reported positions in order. Each raw position has its two lowest bits inverted, which gives a bit address. An address that points past the data area, into the check bytes, is skipped. For an address inside the data area the block reads the byte from the sector buffer, inverts the addressed bit and writes the byte back.

When the walk ends, a one-cycle `done` pulse presents the number of bits that were actually flipped. If the count is above what the code can correct, the block instead flags the sector as uncorrectable and leaves the buffer alone.

The sector buffer is outside this block. It is reached through a byte-wide port with a one-cycle read latency.

Top module: `sector_bitfix`

## Requirements
- R1: After reset, `done`, `memRdEn`, `memWrEn` and `uncorrectable` are 0 and `fixCount` is 0.
- R2: After `start`, the block makes no buffer access and raises no `done` while `codeReady` is 0. It proceeds once `codeReady` is 1.
- R3: An error count (`errCount`) of 0 gives `done` with `fixCount` 0 and `uncorrectable` 0, and the buffer is not accessed.
- R4: An error count above 8 gives `done` with `uncorrectable` 1 and `fixCount` 0, and the buffer is not accessed.
- R5: Let P = {`locTopByte`, `locWord3`, `locWord2`, `locWord1`}, 104 bits. Raw position k (k = 0..7) is P[13k+12 : 13k]. So position 2 is {word2[6:0], word1[31:26]}, position 4 is {word3[0], word2[31:20]} and position 7 is {topByte, word3[31:27]}.
- R6: Bit address A = raw position XOR 3, which inverts bits 0 and 1.
- R7: An address A ≥ 4096 is skipped: no access, and it is not counted.
- R8: An in-range A reads byte A[11:3] and, in the next cycle, writes to the same byte the read value with bit A[2:0] inverted.
- R9: `fixCount` at `done` equals the number of in-range addresses applied. `done` is high for exactly one cycle.
- R10: Only the first `errCount` positions are used. Positions beyond the count leave the buffer unchanged.
- R11: Repeated or same-byte addresses are applied in order, each on the result of the previous one. The same bit listed twice ends unchanged and counts 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a correction pass |
| codeReady | input | 1 | Decoder result valid |
| errCount | input | 4 | Number of reported error positions |
| locWord1 | input | 32 | Packed positions, bits 31:0 |
| locWord2 | input | 32 | Packed positions, bits 63:32 |
| locWord3 | input | 32 | Packed positions, bits 95:64 |
| locTopByte | input | 8 | Packed positions, bits 103:96 |
| memAddr | output | 9 | Sector buffer byte address |
| memRdEn | output | 1 | Buffer read request (data next cycle) |
| memRdData | input | 8 | Buffer read data |
| memWrEn | output | 1 | Buffer write strobe |
| memWrData | output | 8 | Buffer write data |
| done | output | 1 | One-cycle completion pulse |
| fixCount | output | 4 | Bits corrected |
| uncorrectable | output | 1 | Count exceeded correction capability |

## Verification
The bench places positions so that they straddle every 32-bit word boundary and the extra byte. A wrong unpack therefore flips the wrong bits, and the buffer comparison catches it. It tests the very last data bit (address 4095) next to the first check-area addresses (4096 and above): an off-by-one range test either corrupts data or miscounts.

Counts of 0, 9 and 15 must leave the buffer untouched. Extra valid-looking positions beyond the count must be ignored. Two flips inside one byte, and one bit flipped twice, expose a read-modify-write that uses stale data.

A pass started before the ready flag is set must stay silent until the flag rises.

// File: rtl/sector_bitfix_pkg.sv
package sector_bitfix_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_RDY,
    ST_DECIDE,
    ST_PROBE,
    ST_MODIFY,
    ST_FINISH
  } fixState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearResult;
    logic capture;
    logic markUnc;
    logic memRead;
    logic memWrite;
    logic fixInc;
    logic slotNext;
  } fixStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic cntZero;
    logic cntOver;
    logic inRange;
    logic lastSlot;
  } fixFlags_t;

endpackage

// File: rtl/sector_bitfix_dp.sv
module sector_bitfix_dp
  import sector_bitfix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int LOC_W        = 13,
  parameter int MAX_FIX      = 8,
  parameter int CNT_W        = 4,
  parameter int BYTE_AW      = $clog2(SECTOR_BYTES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  fixStrobe_t         strobe,
  output fixFlags_t          flags,
  input  logic [CNT_W-1:0]   errCount,
  input  logic [31:0]        locWord1,
  input  logic [31:0]        locWord2,
  input  logic [31:0]        locWord3,
  input  logic [7:0]         locTopByte,
  output logic [BYTE_AW-1:0] memAddr,
  output logic               memRdEn,
  input  logic [7:0]         memRdData,
  output logic               memWrEn,
  output logic [7:0]         memWrData,
  output logic [CNT_W-1:0]   fixCount,
  output logic               uncorrectable
);

  localparam int DATA_BITS = SECTOR_BYTES * 8;
  localparam int PACK_W    = LOC_W * MAX_FIX;
  localparam int SLOT_W    = $clog2(MAX_FIX);

  logic [PACK_W-1:0] packedLocs;
  logic [CNT_W-1:0]  heldCount;
  logic [SLOT_W-1:0] slotIdx;
  logic [LOC_W-1:0]  slotLoc [MAX_FIX];
  logic [LOC_W-1:0]  bitAddr;
  logic [7:0]        flipMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      packedLocs    <= '0;
      heldCount     <= '0;
      slotIdx       <= '0;
      fixCount      <= '0;
      uncorrectable <= 1'b0;
    end else begin
      if (strobe.clearResult) begin
        fixCount      <= '0;
        uncorrectable <= 1'b0;
      end
      if (strobe.capture) begin
        packedLocs <= PACK_W'({locTopByte, locWord3, locWord2, locWord1});
        heldCount  <= errCount;
        slotIdx    <= '0;
      end
      if (strobe.markUnc)  uncorrectable <= 1'b1;
      if (strobe.fixInc)   fixCount      <= fixCount + CNT_W'(1);
      if (strobe.slotNext) slotIdx       <= slotIdx + SLOT_W'(1);
    end
  end

  // fixed-width unpack of the position fields
  for (genvar k = 0; k < MAX_FIX; k++) begin : g_unpack
    assign slotLoc[k] = packedLocs[LOC_W*k +: LOC_W];
  end

  always_comb begin
    bitAddr  = slotLoc[slotIdx] ^ LOC_W'(3);
    flipMask = 8'(1) << bitAddr[2:0];
  end

  assign flags.cntZero  = (heldCount == '0);
  assign flags.cntOver  = (heldCount > CNT_W'(MAX_FIX));
  assign flags.inRange  = (bitAddr < LOC_W'(DATA_BITS));
  assign flags.lastSlot = (CNT_W'(slotIdx) == heldCount - CNT_W'(1));

  assign memAddr   = bitAddr[BYTE_AW+2:3];
  assign memRdEn   = strobe.memRead;
  assign memWrEn   = strobe.memWrite;
  assign memWrData = memRdData ^ flipMask;

endmodule

// File: rtl/sector_bitfix_ctl.sv
module sector_bitfix_ctl
  import sector_bitfix_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       codeReady,
  input  fixFlags_t  flags,
  output fixStrobe_t strobe,
  output logic       done
);

  fixState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.clearResult = 1'b1;
          nextState          = ST_WAIT_RDY;
        end
      end
      ST_WAIT_RDY: begin
        if (codeReady) begin
          strobe.capture = 1'b1;
          nextState      = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        if (flags.cntZero) begin
          nextState = ST_FINISH;
        end else if (flags.cntOver) begin
          strobe.markUnc = 1'b1;
          nextState      = ST_FINISH;
        end else begin
          nextState = ST_PROBE;
        end
      end
      ST_PROBE: begin
        if (flags.inRange) begin
          strobe.memRead = 1'b1;
          nextState      = ST_MODIFY;
        end else if (flags.lastSlot) begin
          nextState = ST_FINISH;
        end else begin
          strobe.slotNext = 1'b1;
        end
      end
      ST_MODIFY: begin
        strobe.memWrite = 1'b1;
        strobe.fixInc   = 1'b1;
        if (flags.lastSlot) begin
          nextState = ST_FINISH;
        end else begin
          strobe.slotNext = 1'b1;
          nextState       = ST_PROBE;
        end
      end
      ST_FINISH: begin
        done      = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/sector_bitfix.sv
module sector_bitfix
  import sector_bitfix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int LOC_W        = 13,
  parameter int MAX_FIX      = 8,
  parameter int CNT_W        = 4,
  parameter int BYTE_AW      = $clog2(SECTOR_BYTES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               codeReady,
  input  logic [CNT_W-1:0]   errCount,
  input  logic [31:0]        locWord1,
  input  logic [31:0]        locWord2,
  input  logic [31:0]        locWord3,
  input  logic [7:0]         locTopByte,
  output logic [BYTE_AW-1:0] memAddr,
  output logic               memRdEn,
  input  logic [7:0]         memRdData,
  output logic               memWrEn,
  output logic [7:0]         memWrData,
  output logic               done,
  output logic [CNT_W-1:0]   fixCount,
  output logic               uncorrectable
);

  fixStrobe_t strobe;
  fixFlags_t  flags;

  sector_bitfix_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .codeReady (codeReady),
    .flags     (flags),
    .strobe    (strobe),
    .done      (done)
  );

  sector_bitfix_dp #(
    .SECTOR_BYTES (SECTOR_BYTES),
    .LOC_W        (LOC_W),
    .MAX_FIX      (MAX_FIX),
    .CNT_W        (CNT_W),
    .BYTE_AW      (BYTE_AW)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .flags         (flags),
    .errCount      (errCount),
    .locWord1      (locWord1),
    .locWord2      (locWord2),
    .locWord3      (locWord3),
    .locTopByte    (locTopByte),
    .memAddr       (memAddr),
    .memRdEn       (memRdEn),
    .memRdData     (memRdData),
    .memWrEn       (memWrEn),
    .memWrData     (memWrData),
    .fixCount      (fixCount),
    .uncorrectable (uncorrectable)
  );

endmodule

// File: rtl/sector_bitfix_chk.sv
module sector_bitfix_chk #(
  parameter int CNT_W   = 4,
  parameter int BYTE_AW = 9,
  parameter int MAX_FIX = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [BYTE_AW-1:0] memAddr,
  input logic               memRdEn,
  input logic [7:0]         memRdData,
  input logic               memWrEn,
  input logic [7:0]         memWrData,
  input logic               done,
  input logic [CNT_W-1:0]   fixCount,
  input logic               uncorrectable
);

  assert_rw_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn));

  assert_write_after_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> $past(memRdEn));

  assert_write_same_byte_R8: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> memAddr == $past(memAddr));

  assert_single_bit_flip_R8: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> $countones(memWrData ^ memRdData) == 1);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_fix_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> fixCount <= CNT_W'(MAX_FIX));

  assert_unc_no_fix_R4: assert property (@(posedge clk) disable iff (!rstN)
    (done && uncorrectable) |-> fixCount == '0);

  assert_no_access_at_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memRdEn && !memWrEn);

endmodule

bind sector_bitfix sector_bitfix_chk #(
  .CNT_W   (CNT_W),
  .BYTE_AW (BYTE_AW),
  .MAX_FIX (MAX_FIX)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .memAddr       (memAddr),
  .memRdEn       (memRdEn),
  .memRdData     (memRdData),
  .memWrEn       (memWrEn),
  .memWrData     (memWrData),
  .done          (done),
  .fixCount      (fixCount),
  .uncorrectable (uncorrectable)
);

// File: tb/sim_sector_bitfix.sv
`timescale 1ns/1ps
module sim_sector_bitfix;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        codeReady = 1'b0;
  logic [3:0]  errCount = '0;
  logic [31:0] locWord1 = '0, locWord2 = '0, locWord3 = '0;
  logic [7:0]  locTopByte = '0;
  logic [8:0]  memAddr;
  logic        memRdEn, memWrEn;
  logic [7:0]  memRdData, memWrData;
  logic        done;
  logic [3:0]  fixCount;
  logic        uncorrectable;

  int checks = 0;
  int failures = 0;
  int accessCount = 0;
  int cycleCount = 0;

  logic [7:0] mem    [512];
  logic [7:0] expMem [512];

  always #5 clk = ~clk;

  sector_bitfix u0 (
    .clk(clk), .rstN(rstN), .start(start), .codeReady(codeReady),
    .errCount(errCount), .locWord1(locWord1), .locWord2(locWord2),
    .locWord3(locWord3), .locTopByte(locTopByte),
    .memAddr(memAddr), .memRdEn(memRdEn), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrData(memWrData),
    .done(done), .fixCount(fixCount), .uncorrectable(uncorrectable)
  );

  // sector buffer model: one-cycle read latency
  always @(posedge clk) begin
    if (memRdEn) memRdData <= mem[memAddr];
    if (memWrEn) mem[memAddr] <= memWrData;
    if (memRdEn || memWrEn) accessCount <= accessCount + 1;
  end

  localparam int NV = 8;
  localparam logic [3:0]  TV_CNT [NV] = '{4'd1, 4'd8, 4'd3, 4'd0, 4'd9, 4'd15, 4'd2, 4'd2};
  localparam logic [12:0] TV_LOC [NV][8] = '{
    '{13'h0000, 13'h0000, 13'h0000, 13'h0000, 13'h0000, 13'h0000, 13'h0000, 13'h0000},
    '{13'h0003, 13'h0FFC, 13'h0123, 13'h0456, 13'h0789, 13'h0ABC, 13'h0DEF, 13'h0F00},
    '{13'h1003, 13'h0010, 13'h1FFF, 13'h0055, 13'h0066, 13'h0077, 13'h0088, 13'h0099},
    '{13'h0011, 13'h0022, 13'h0033, 13'h0044, 13'h0055, 13'h0066, 13'h0077, 13'h0088},
    '{13'h0011, 13'h0022, 13'h0033, 13'h0044, 13'h0055, 13'h0066, 13'h0077, 13'h0088},
    '{13'h0101, 13'h0202, 13'h0303, 13'h0404, 13'h0505, 13'h0606, 13'h0707, 13'h0808},
    '{13'h0021, 13'h0026, 13'h0100, 13'h0200, 13'h0300, 13'h0400, 13'h0500, 13'h0600},
    '{13'h0040, 13'h0040, 13'h0000, 13'h0000, 13'h0000, 13'h0000, 13'h0000, 13'h0000}
  };
  localparam logic [3:0] TV_FIX [NV] = '{4'd1, 4'd8, 4'd1, 4'd0, 4'd0, 4'd0, 4'd2, 4'd2};
  localparam logic       TV_UNC [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic initMem();
    for (int i = 0; i < 512; i++) begin
      mem[i]    = 8'(i * 7 + 3);
      expMem[i] = 8'(i * 7 + 3);
    end
  endtask

  // pack positions per R5 and compute expected buffer per R6/R7/R8/R10/R11
  task automatic loadVector(input int v);
    logic [103:0] vec;
    vec = '0;
    for (int i = 0; i < 8; i++) vec[13*i +: 13] = TV_LOC[v][i];
    locWord1   = vec[31:0];
    locWord2   = vec[63:32];
    locWord3   = vec[95:64];
    locTopByte = vec[103:96];
    errCount   = TV_CNT[v];
    if (TV_CNT[v] <= 4'd8) begin
      for (int i = 0; i < int'(TV_CNT[v]); i++) begin
        int a;
        a = int'(TV_LOC[v][i] ^ 13'd3);
        if (a < 4096) expMem[a / 8] = expMem[a / 8] ^ 8'(1 << (a % 8));
      end
    end
  endtask

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // returns 1 if done seen; leaves time at negedge of done cycle
  task automatic waitDone(output bit seen);
    seen = 1'b0;
    for (int t = 0; t < 200; t++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  function automatic int memMismatches();
    int n = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== expMem[i]) n++;
    return n;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycleCount++;
      if (cycleCount > 100000) begin
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=0", cycleCount);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    bit seen;
    int startAcc;
    initMem();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "done", int'(done), 0);
    check("R1", "memRdEn", int'(memRdEn), 0);
    check("R1", "memWrEn", int'(memWrEn), 0);
    check("R1", "fixCount", int'(fixCount), 0);
    check("R1", "uncorrectable", int'(uncorrectable), 0);
    rstN = 1'b1;
    @(negedge clk);

    codeReady = 1'b1;
    for (int v = 0; v < NV; v++) begin
      initMem();
      loadVector(v);
      startAcc = accessCount;
      pulseStart();
      waitDone(seen);
      check("R9", $sformatf("v%0d done seen", v), int'(seen), 1);
      check("R9", $sformatf("v%0d fixCount", v), int'(fixCount), int'(TV_FIX[v]));
      check("R4", $sformatf("v%0d uncorrectable", v), int'(uncorrectable), int'(TV_UNC[v]));
      @(negedge clk);
      check("R9", $sformatf("v%0d done one cycle", v), int'(done), 0);
      check("R8", $sformatf("v%0d buffer mismatches", v), memMismatches(), 0);
      // each applied flip is one read plus one write (R3 R4 R7 R10)
      check("R7", $sformatf("v%0d accesses", v), accessCount - startAcc, 2 * int'(TV_FIX[v]));
    end

    // R2 wait for ready flag
    codeReady = 1'b0;
    initMem();
    loadVector(0);
    startAcc = accessCount;
    pulseStart();
    begin
      int doneSeen = 0;
      for (int t = 0; t < 12; t++) begin
        @(negedge clk);
        if (done) doneSeen++;
      end
      check("R2", "done while not ready", doneSeen, 0);
      check("R2", "accesses while not ready", accessCount - startAcc, 0);
    end
    codeReady = 1'b1;
    waitDone(seen);
    check("R2", "done after ready", int'(seen), 1);
    check("R2", "fixCount after ready", int'(fixCount), 1);
    @(negedge clk);
    check("R2", "buffer after ready", memMismatches(), 0);

    // R3 count zero with in-range positions present
    initMem();
    loadVector(3);
    startAcc = accessCount;
    pulseStart();
    waitDone(seen);
    check("R3", "zero count fixCount", int'(fixCount), 0);
    @(negedge clk);
    check("R3", "zero count buffer", memMismatches(), 0);
    check("R3", "zero count accesses", accessCount - startAcc, 0);

    // R11 repeat of one bit restores byte and counts two
    initMem();
    loadVector(7);
    pulseStart();
    waitDone(seen);
    check("R11", "double flip count", int'(fixCount), 2);
    @(negedge clk);
    check("R11", "double flip byte", int'(mem[8'h08]), int'(8'(8 * 7 + 3)));

    // R5 R6 R10: last data bit 4095 flipped, positions past count ignored
    initMem();
    loadVector(1);
    pulseStart();
    waitDone(seen);
    @(negedge clk);
    check("R6", "last data byte", int'(mem[511]), int'(8'(511 * 7 + 3) ^ 8'h80));
    check("R5", "position 7 byte", int'(mem[13'h0F03 >> 3]), int'(expMem[13'h0F03 >> 3]));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule